// File: doc/BRIEF.md
# Outbound Bridge Transaction Queue

This block sits between a local bus master and an outbound bus-master engine. Every local request carries a direction, an address and a burst length. It is stored as one entry in a small transaction queue. Write data goes into a transmit FIFO and read data comes back through a receive FIFO. The engine on the far side takes entries from the head of the queue with a valid/ready handshake. For a write entry it pulls the data words from the transmit FIFO one strobe at a time. For a read entry it pushes the returned words into the receive FIFO.

Writes are posted. The local side is released in the cycle it presents a write, provided the queue has a free entry and the transmit FIFO can hold the whole burst. The data words then follow, one per `lcl_wvalid` beat. The entry enters the queue with the last beat, so the far side never sees a write entry before all of its data is stored.

A read holds the local side in wait for its whole life. It waits for a free entry. It then waits behind every older entry until the far side takes it. Finally it waits for its data to come back through the receive FIFO. The acknowledge comes with the last returned word, so a finished read means every queue has drained.

Status outputs report:
- transmit FIFO full;
- transmit FIFO empty;
- transaction queue full;
- a sticky transmit-empty flag, which drives an interrupt when enabled.

Top module: `obq_bridge`

## Requirements
- R1: A write with a legal length (1 to 8) is acknowledged in the same cycle it is presented in the idle state when the queue holds fewer than 4 entries and the transmit word count plus the length is at most 8. Its data words are then taken on the following `lcl_wvalid` beats.
- R2: A write is held (`lcl_ack` low) while the transmit FIFO lacks room for the whole burst, even when the transaction queue holds only one entry.
- R3: While the transaction queue holds 4 entries, no new read or write with a legal length is acknowledged.
- R4: A read is acknowledged together with its last returned word. Its words appear on `lcl_rdata` with `lcl_rvalid` in the order the far side returned them, and exactly `lcl_len` of them come before the acknowledge.
- R5: Entries leave on `out_*` in the order the local side issued them, and each offered entry stays stable until taken. Write data leaves on `out_wdata` in the order it was written. A write entry is offered only after all of its words are in the transmit FIFO.
- R6: A request with length 0 or more than 8 is acknowledged at once with `lcl_err` high, and nothing is queued.
- R7: `tx_full` is high exactly when the transmit FIFO holds 8 words, `tx_empty` exactly when it holds none, and `txq_full` exactly when the queue holds 4 entries.
- R8: `tx_empty_stky` is set in the cycle after `tx_empty` rises. A one-cycle `stky_clr` clears it, unless a new rise of `tx_empty` sets it in the same cycle, in which case the set wins.
- R9: `irq` is high exactly when `tx_empty_stky` and `irq_en` are both high.
- R10: After reset no request is acknowledged, `out_valid`, `tx_full`, `txq_full`, `tx_empty_stky` and `irq` are low, and `tx_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_req | input | 1 | Local request, held until acknowledged |
| lcl_wr | input | 1 | 1 = write, 0 = read |
| lcl_addr | input | 32 | Request address |
| lcl_len | input | 4 | Burst length in words, legal 1..8 |
| lcl_ack | output | 1 | Request accepted (write) or completed (read, error) |
| lcl_err | output | 1 | Illegal length, valid with `lcl_ack` |
| lcl_wvalid | input | 1 | Write data beat |
| lcl_wdata | input | 32 | Write data word |
| lcl_rvalid | output | 1 | Read data word valid |
| lcl_rdata | output | 32 | Read data word |
| out_valid | output | 1 | Queue head entry offered |
| out_ready | input | 1 | Far side takes the head entry |
| out_wr | output | 1 | Head entry direction |
| out_addr | output | 32 | Head entry address |
| out_len | output | 4 | Head entry length |
| out_wdata | output | 32 | Transmit FIFO head word |
| out_wpop | input | 1 | Far side consumes one transmit word |
| in_rvalid | input | 1 | Far side returns one read word |
| in_rdata | input | 32 | Returned read word |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| txq_full | output | 1 | Transaction queue full |
| tx_empty_stky | output | 1 | Sticky transmit-empty flag |
| stky_clr | input | 1 | Clear strobe for the sticky flag |
| irq_en | input | 1 | Interrupt enable for the sticky flag |
| irq | output | 1 | Transmit-empty interrupt |

## Verification
The hardest states to reach are the two stall conditions: the queue filled to exactly four entries, and a write blocked by transmit space while only one entry waits. Both need the far side to stop consuming at a chosen moment. The far-side model in the bench has a stall switch for this. The directed steps turn it on, fill the queues to the chosen level, hold a new request for several cycles while confirming it is not acknowledged, then release the far side. Random traffic with a randomly ready far side follows, checking ordering, data and error responses.

// File: rtl/obq_pkg.sv
package obq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WDATA = 2'd1,
        ST_RDATA = 2'd2
    } obq_state_e;

endpackage

// File: rtl/obq_fifo.sv
module obq_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wp = nxt(st_q.wp);
        if (do_pop)  st_d.rp = nxt(st_q.rp);
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + CW'(1);
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= din;
    end

    assign dout  = mem_q[st_q.rp];
    assign count = st_q.cnt;

endmodule

// File: rtl/obq_bridge.sv
module obq_bridge
    import obq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 4,
    parameter int MAX_BURST = 8,
    parameter int TX_DEPTH  = 8,
    parameter int RX_DEPTH  = 8,
    parameter int TXQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lcl_req,
    input  logic              lcl_wr,
    input  logic [ADDR_W-1:0] lcl_addr,
    input  logic [LEN_W-1:0]  lcl_len,
    output logic              lcl_ack,
    output logic              lcl_err,
    input  logic              lcl_wvalid,
    input  logic [DATA_W-1:0] lcl_wdata,
    output logic              lcl_rvalid,
    output logic [DATA_W-1:0] lcl_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_wr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic [DATA_W-1:0] out_wdata,
    input  logic              out_wpop,
    input  logic              in_rvalid,
    input  logic [DATA_W-1:0] in_rdata,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              txq_full,
    output logic              tx_empty_stky,
    input  logic              stky_clr,
    input  logic              irq_en,
    output logic              irq
);

    localparam int ENT_W  = 1 + ADDR_W + LEN_W;
    localparam int TX_CW  = $clog2(TX_DEPTH + 1);
    localparam int RX_CW  = $clog2(RX_DEPTH + 1);
    localparam int TXQ_CW = $clog2(TXQ_DEPTH + 1);

    typedef struct packed {
        obq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic              stky;
        logic              empty_prev;
    } ctl_t;

    ctl_t q, d;

    logic [TX_CW-1:0]  tx_cnt;
    logic [RX_CW-1:0]  rx_cnt;
    logic [TXQ_CW-1:0] txq_cnt;
    logic              tx_push, txq_push, rx_pop, rx_push;
    logic [ENT_W-1:0]  txq_din, txq_dout;
    logic              len_ok, tx_room, rx_empty, last_beat, set_stky;

    obq_fifo #(.W(ENT_W), .DEPTH(TXQ_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(txq_push), .din(txq_din),
        .pop(out_valid && out_ready), .dout(txq_dout),
        .count(txq_cnt)
    );

    obq_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .din(lcl_wdata),
        .pop(out_wpop), .dout(out_wdata),
        .count(tx_cnt)
    );

    obq_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(in_rdata),
        .pop(rx_pop), .dout(lcl_rdata),
        .count(rx_cnt)
    );

    assign tx_full   = (tx_cnt == TX_CW'(TX_DEPTH));
    assign tx_empty  = (tx_cnt == '0);
    assign txq_full  = (txq_cnt == TXQ_CW'(TXQ_DEPTH));
    assign out_valid = (txq_cnt != '0);
    assign rx_empty  = (rx_cnt == '0);
    assign rx_push   = in_rvalid && (rx_cnt != RX_CW'(RX_DEPTH));
    assign {out_wr, out_addr, out_len} = txq_dout;

    always_comb begin
        d          = q;
        lcl_ack    = 1'b0;
        lcl_err    = 1'b0;
        lcl_rvalid = 1'b0;
        tx_push    = 1'b0;
        txq_push   = 1'b0;
        rx_pop     = 1'b0;
        txq_din    = {1'b1, q.addr, q.len};
        len_ok     = (lcl_len != '0) && (32'(lcl_len) <= MAX_BURST);
        tx_room    = (32'(tx_cnt) + 32'(lcl_len)) <= TX_DEPTH;
        last_beat  = (q.cnt == (q.len - LEN_W'(1)));

        case (q.st)
            ST_IDLE: begin
                if (lcl_req) begin
                    if (!len_ok) begin
                        lcl_ack = 1'b1;
                        lcl_err = 1'b1;
                    end else if (!txq_full) begin
                        if (lcl_wr) begin
                            if (tx_room) begin
                                lcl_ack = 1'b1;
                                d.st    = ST_WDATA;
                                d.addr  = lcl_addr;
                                d.len   = lcl_len;
                                d.cnt   = '0;
                            end
                        end else begin
                            txq_push = 1'b1;
                            txq_din  = {1'b0, lcl_addr, lcl_len};
                            d.st     = ST_RDATA;
                            d.len    = lcl_len;
                            d.cnt    = '0;
                        end
                    end
                end
            end
            ST_WDATA: begin
                if (lcl_wvalid) begin
                    tx_push = 1'b1;
                    if (last_beat) begin
                        txq_push = 1'b1;
                        d.st     = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + LEN_W'(1);
                    end
                end
            end
            ST_RDATA: begin
                if (!rx_empty) begin
                    rx_pop     = 1'b1;
                    lcl_rvalid = 1'b1;
                    if (last_beat) begin
                        lcl_ack = 1'b1;
                        d.st    = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + LEN_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        set_stky     = tx_empty && !q.empty_prev;
        d.empty_prev = tx_empty;
        if (set_stky)      d.stky = 1'b1;
        else if (stky_clr) d.stky = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q            <= '0;
            q.st         <= ST_IDLE;
            q.empty_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_empty_stky = q.stky;
    assign irq           = q.stky && irq_en;

endmodule

// File: rtl/obq_checker.sv
module obq_checker #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 4,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int TX_CW   = $clog2(TX_DEPTH + 1),
    localparam int RX_CW   = $clog2(RX_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lcl_wr,
    input logic [LEN_W-1:0]  lcl_len,
    input logic              lcl_ack,
    input logic              lcl_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [LEN_W-1:0]  out_len,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              txq_full,
    input logic              tx_empty_stky,
    input logic              stky_clr,
    input logic [TX_CW-1:0]  tx_cnt,
    input logic [RX_CW-1:0]  rx_cnt
);

    p_wr_room_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_ack && lcl_wr && !lcl_err) |-> (32'(tx_cnt) + 32'(lcl_len) <= TX_DEPTH));

    p_txq_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        txq_full |-> !(lcl_ack && !lcl_err));

    p_head_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len)));

    p_err_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_err |-> lcl_ack);

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tx_cnt) <= TX_DEPTH) && (32'(rx_cnt) <= RX_DEPTH));

    p_stky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |=> tx_empty_stky);

    p_stky_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stky_clr && $stable(tx_empty)) |=> !tx_empty_stky);

endmodule

bind obq_bridge obq_checker #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)
) u_obq_chk (
    .clk(clk), .rst_n(rst_n), .lcl_wr(lcl_wr), .lcl_len(lcl_len),
    .lcl_ack(lcl_ack), .lcl_err(lcl_err), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_len(out_len),
    .tx_full(tx_full), .tx_empty(tx_empty), .txq_full(txq_full),
    .tx_empty_stky(tx_empty_stky), .stky_clr(stky_clr),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_obq_bridge.sv
`timescale 1ns/1ps
module test_obq_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lcl_req = 0, lcl_wr = 0, lcl_wvalid = 0;
    logic [31:0] lcl_addr = '0, lcl_wdata = '0;
    logic [3:0]  lcl_len = '0;
    logic        lcl_ack, lcl_err, lcl_rvalid;
    logic [31:0] lcl_rdata;
    logic        out_valid, out_wr;
    logic        out_ready = 0, out_wpop = 0, in_rvalid = 0;
    logic [31:0] out_addr, out_wdata;
    logic [31:0] in_rdata = '0;
    logic [3:0]  out_len;
    logic        tx_full, tx_empty, txq_full, tx_empty_stky, irq;
    logic        stky_clr = 0, irq_en = 0;

    int chk_n  = 0;
    int fail_n = 0;
    bit done   = 0;
    bit far_stall = 0;
    int wr_left = 0, rd_left = 0, rd_idx = 0;
    logic [31:0] rd_addr = '0;
    logic [36:0] exp_txn[$];
    logic [31:0] exp_wd[$];

    always #2 clk = ~clk;

    obq_bridge i_obq_bridge (
        .clk(clk), .rst_n(rst_n),
        .lcl_req(lcl_req), .lcl_wr(lcl_wr), .lcl_addr(lcl_addr), .lcl_len(lcl_len),
        .lcl_ack(lcl_ack), .lcl_err(lcl_err),
        .lcl_wvalid(lcl_wvalid), .lcl_wdata(lcl_wdata),
        .lcl_rvalid(lcl_rvalid), .lcl_rdata(lcl_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_wr(out_wr),
        .out_addr(out_addr), .out_len(out_len), .out_wdata(out_wdata),
        .out_wpop(out_wpop), .in_rvalid(in_rvalid), .in_rdata(in_rdata),
        .tx_full(tx_full), .tx_empty(tx_empty), .txq_full(txq_full),
        .tx_empty_stky(tx_empty_stky), .stky_clr(stky_clr),
        .irq_en(irq_en), .irq(irq)
    );

    function automatic logic [31:0] rd_word(input logic [31:0] a, input int i);
        return a ^ (32'(i) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
    endfunction

    function automatic bit len_legal(input logic [3:0] l);
        return (l >= 4'd1) && (l <= 4'd8);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        chk_n++;
        if (!ok) begin
            fail_n++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", chk_n, fail_n);
    endtask

    // Far-side engine model: takes entries, drains write words, returns read words
    always @(negedge clk) begin
        out_wpop  = 0;
        in_rvalid = 0;
        out_ready = 0;
        if (rst_n) begin
            if (wr_left > 0) begin
                if (exp_wd.size() == 0) chk(0, "R5 write data", out_wdata, 0);
                else begin
                    chk(out_wdata == exp_wd[0], "R5 write data order", out_wdata, exp_wd[0]);
                    void'(exp_wd.pop_front());
                end
                out_wpop = 1;
                wr_left--;
            end else if (rd_left > 0) begin
                in_rvalid = 1;
                in_rdata  = rd_word(rd_addr, rd_idx);
                rd_idx++;
                rd_left--;
            end else if (!far_stall && ($urandom_range(0, 9) < 7)) begin
                out_ready = 1;
                if (out_valid) begin
                    if (exp_txn.size() == 0) chk(0, "R5 entry order", {out_wr, out_addr, out_len}, 0);
                    else begin
                        chk({out_wr, out_addr, out_len} == exp_txn[0], "R5 entry order",
                            {out_wr, out_addr, out_len}, exp_txn[0]);
                        void'(exp_txn.pop_front());
                    end
                    if (out_wr) wr_left = int'(out_len);
                    else begin
                        rd_left = int'(out_len);
                        rd_addr = out_addr;
                        rd_idx  = 0;
                    end
                end
            end
        end
    end

    // Write: hold_n cycles of checked stall, then release far side and wait
    task automatic do_write(input logic [31:0] a, input logic [3:0] l, input int hold_n);
        int cyc = 0;
        @(negedge clk);
        lcl_req = 1; lcl_wr = 1; lcl_addr = a; lcl_len = l;
        if (len_legal(l)) exp_txn.push_back({1'b1, a, l});
        forever begin
            #1;
            if (cyc < hold_n) chk(lcl_ack == 0, "R2/R3 write held", lcl_ack, 0);
            else if (lcl_ack) break;
            cyc++;
            if (cyc == hold_n) far_stall = 0;
            @(negedge clk);
        end
        chk(lcl_err == !len_legal(l), "R6 error flag", lcl_err, !len_legal(l));
        if (len_legal(l)) begin
            for (int i = 0; i < int'(l); i++) begin
                @(negedge clk);
                lcl_req = 0; lcl_wvalid = 1; lcl_wdata = $urandom();
                exp_wd.push_back(lcl_wdata);
            end
        end
        @(negedge clk);
        lcl_req = 0; lcl_wvalid = 0;
    endtask

    task automatic do_read(input logic [31:0] a, input logic [3:0] l, input int hold_n);
        int cyc = 0;
        int got = 0;
        @(negedge clk);
        lcl_req = 1; lcl_wr = 0; lcl_addr = a; lcl_len = l;
        if (len_legal(l)) exp_txn.push_back({1'b0, a, l});
        forever begin
            #1;
            if (cyc < hold_n) chk(lcl_ack == 0, "R3 read held", lcl_ack, 0);
            if (lcl_rvalid) begin
                chk(lcl_rdata == rd_word(a, got), "R4 read data", lcl_rdata, rd_word(a, got));
                got++;
            end
            if (lcl_ack) break;
            cyc++;
            if (cyc == hold_n) far_stall = 0;
            @(negedge clk);
        end
        chk(lcl_err == !len_legal(l), "R6 error flag", lcl_err, !len_legal(l));
        if (len_legal(l)) chk(got == int'(l), "R4 words before ack", got, l);
        else chk(got == 0, "R6 nothing returned", got, 0);
        @(negedge clk);
        lcl_req = 0;
    endtask

    task automatic wait_drain();
        while (exp_txn.size() != 0 || wr_left != 0 || rd_left != 0 || !tx_empty) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fail_n++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        // R10 reset state
        chk(lcl_ack == 0, "R10 ack", lcl_ack, 0);
        chk(out_valid == 0, "R10 out_valid", out_valid, 0);
        chk(tx_empty == 1 && tx_full == 0 && txq_full == 0, "R10 flags",
            {tx_empty, tx_full, txq_full}, 3'b100);
        chk(tx_empty_stky == 0 && irq == 0, "R10 sticky", {tx_empty_stky, irq}, 0);

        // R1 R4 R5 basic traffic
        do_write(32'h1000_0000, 4'd4, 0);
        do_read(32'h2000_0040, 4'd3, 0);
        do_write(32'h1000_0100, 4'd1, 0);
        do_read(32'h2000_0080, 4'd8, 0);
        wait_drain();

        // R7 full flag, then R8/R9 sticky and interrupt
        far_stall = 1;
        do_write(32'h3000_0000, 4'd8, 0);
        #1;
        chk(tx_full == 1 && tx_empty == 0, "R7 tx full", {tx_full, tx_empty}, 2'b10);
        @(negedge clk);
        stky_clr = 1;
        @(negedge clk);
        stky_clr = 0;
        far_stall = 0;
        wait_drain();
        chk(tx_empty_stky == 1, "R8 sticky set on drain", tx_empty_stky, 1);
        chk(irq == 0, "R9 irq masked", irq, 0);
        irq_en = 1; #1;
        chk(irq == 1, "R9 irq enabled", irq, 1);
        @(negedge clk);
        stky_clr = 1;
        @(negedge clk);
        stky_clr = 0; #1;
        chk(tx_empty_stky == 0 && irq == 0, "R8 sticky cleared", {tx_empty_stky, irq}, 0);
        do_write(32'h3000_0100, 4'd2, 0);
        wait_drain();
        chk(tx_empty_stky == 1, "R8 sticky set again", tx_empty_stky, 1);
        irq_en = 0;

        // R2 transmit space stall with one entry queued
        far_stall = 1;
        do_write(32'h4000_0000, 4'd6, 0);
        #1;
        chk(txq_full == 0, "R2 queue not full", txq_full, 0);
        do_write(32'h4000_0100, 4'd3, 6);
        wait_drain();

        // R3 queue full stalls writes and reads
        far_stall = 1;
        for (int k = 0; k < 4; k++) do_write(32'h5000_0000 + 32'(k * 16), 4'd1, 0);
        #1;
        chk(txq_full == 1, "R7 txq full", txq_full, 1);
        do_write(32'h5000_0100, 4'd1, 5);
        wait_drain();
        far_stall = 1;
        for (int k = 0; k < 4; k++) do_write(32'h5100_0000 + 32'(k * 16), 4'd2, 0);
        do_read(32'h5200_0000, 4'd2, 5);
        wait_drain();

        // R6 illegal lengths
        do_write(32'h6000_0000, 4'd0, 0);
        do_write(32'h6000_0000, 4'd9, 0);
        do_read(32'h6000_0000, 4'd12, 0);
        #1;
        chk(out_valid == 0, "R6 nothing queued", out_valid, 0);

        // constrained random traffic
        for (int n = 0; n < 250; n++) begin
            logic [3:0] l;
            l = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(1, 8));
            if ($urandom_range(0, 1) == 1) do_write($urandom(), l, 0);
            else do_read($urandom(), l, 0);
        end
        wait_drain();
        chk(tx_empty == 1 && out_valid == 0, "R7 final drain", {tx_empty, out_valid}, 2'b10);

        done = 1;
        summary();
        $finish;
    end

endmodule